// File: doc/BRIEF.md
# UART Host Register Slice with Flagged Receive Queue

This block sits between a UART's serial shifters and the host. Received words come in on a push port, each with two flags: a noise flag and a parity-error flag. The block queues them in a small receive FIFO, and the flags travel with their word. The host reads a data register to take the oldest word, and reads an extended register to see the flags of the word that is now at the head. On the transmit side, a one-entry holding register takes a host write. The transmit shifter empties it through a pop port.

For each direction, one enable bit and one select bit decide how the pending condition is signalled. The condition is "holding register empty" for transmit and "FIFO not empty" for receive. The enable bit gates the request. The select bit sends it to the interrupt output when 0 and to the DMA output when 1.

Top module: `uart_host_regs`

Register map. Each register is 8 bits wide, and a read returns its value one cycle after the read strobe.

| Address | Register | Bits |
|---|---|---|
| 0 | data | read pops the receive FIFO; write loads the transmit holding register |
| 1 | control | bit 7 transmit enable, bit 5 receive enable |
| 2 | status | bit 7 transmit empty, bit 5 receive full, bit 3 overrun, bit 2 noise seen, bit 1 parity seen |
| 3 | select | bit 7 transmit select, bit 5 receive select |
| 4 | extended data | bit 7 noisy, bit 6 parity error, for the head word |

## Requirements
- R1: While control bit 7 (transmit enable) is 1 and the transmit holding register is empty, the transmit request is asserted. It appears on `tx_irq` when select bit 7 is 0 and on `tx_dma` when select bit 7 is 1. Both outputs are never high together.
- R2: While control bit 5 (receive enable) is 1 and the receive FIFO is not empty, the receive request is asserted. It appears on `rx_irq` when select bit 5 is 0 and on `rx_dma` when select bit 5 is 1.
- R3: While control bit 5 is 0, `rx_irq` and `rx_dma` both stay low, whatever select bit 5 holds and whatever the FIFO holds.
- R4: The select register (address 3) reads back bit 7 and bit 5 as written. Bit 6 and bits 4 to 0 always read as 0, even after a write of ones.
- R5: A read of address 0 returns the oldest word in the receive FIFO and removes it, so words come out in the order they were pushed.
- R6: A read of address 4 returns the noisy flag in bit 7 and the parity-error flag in bit 6. Both belong to the word at the head of the FIFO, and all other bits read 0. After a pop, the register shows the flags of the next word.
- R7: While the FIFO is empty, a read of address 4 returns 0 and a read of address 0 returns 0. The empty data read changes no state.
- R8: Status bit 5 (receive full) is 1 exactly when the receive FIFO holds at least one word.
- R9: A push while the FIFO holds 8 words is dropped and sets the sticky overrun flag (status bit 3). Writing a 1 to status bit 3 clears the flag, and the stored words are unchanged.
- R10: Status bit 2 (noise seen) and status bit 1 (parity seen) are set by the push of a word that carries that flag. Both clear when the FIFO becomes empty.
- R11: A write to address 0 loads the transmit holding register. `tx_valid` then goes high, `tx_data` carries the word, and status bit 7 (transmit empty) goes to 0. A `tx_pop` empties the register again.
- R12: After reset, all four request outputs are low, control and select read 0, and status reads 0x80.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | DW | Register write data |
| bus_rdata | output | DW | Registered read data, valid the cycle after `bus_rd` |
| rx_push | input | 1 | Receiver shifter pushes a word |
| rx_data | input | DW | Received word |
| rx_noise | input | 1 | Noise detected on the received word |
| rx_perr | input | 1 | Parity error on the received word |
| tx_pop | input | 1 | Transmitter shifter takes the held word |
| tx_data | output | DW | Word in the transmit holding register |
| tx_valid | output | 1 | Transmit holding register is full |
| tx_irq | output | 1 | Transmit interrupt request |
| tx_dma | output | 1 | Transmit DMA request |
| rx_irq | output | 1 | Receive interrupt request |
| rx_dma | output | 1 | Receive DMA request |

## Verification
The hardest case to reach from the ports is the relation between the flags and the word they belong to. The extended register and the sticky status flags must follow each pop across a mix of flagged and clean words, and the sticky flags must clear only when the queue is drained.

The stimulus fills the FIFO past its depth with words whose flag pattern changes from word to word. Every data read is paired with a prior extended-register read, and both are compared with the scoreboard entry for that word. Reads on the empty queue then confirm the zero values and the cleared sticky state.

// File: rtl/uart_host_pkg.sv
package uart_host_pkg;
  localparam int unsigned ADDR_W = 3;

  // Register addresses
  localparam logic [ADDR_W-1:0] A_DATA = 3'd0;
  localparam logic [ADDR_W-1:0] A_CTRL = 3'd1;
  localparam logic [ADDR_W-1:0] A_STAT = 3'd2;
  localparam logic [ADDR_W-1:0] A_SEL  = 3'd3;
  localparam logic [ADDR_W-1:0] A_EXT  = 3'd4;

  // Bit positions shared by control, select, status and extended data
  localparam int unsigned B_TX    = 7;
  localparam int unsigned B_RX    = 5;
  localparam int unsigned B_OVR   = 3;
  localparam int unsigned B_NSEEN = 2;
  localparam int unsigned B_PSEEN = 1;
  localparam int unsigned B_NOISY = 7;
  localparam int unsigned B_PERR  = 6;

  // Direction index used by the request steering
  typedef enum int unsigned {DIR_TX = 0, DIR_RX = 1} dir_e;
endpackage

// File: rtl/rx_flag_fifo.sv
module rx_flag_fifo #(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          push_noise,
  input  logic          push_perr,
  input  logic          pop,
  input  logic          ovr_clr,
  output logic [DW-1:0] head_data,
  output logic          head_noise,
  output logic          head_perr,
  output logic          empty,
  output logic          full,
  output logic          overrun,
  output logic          noise_seen,
  output logic          perr_seen
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam int unsigned EW = DW + 2;

  logic [EW-1:0] mem [DEPTH];
  logic [PW-1:0] wptr, rptr;
  logic [CW-1:0] cnt, cnt_nx;
  logic          push_ok, pop_ok;

  assign empty   = (cnt == '0);
  assign full    = (cnt == CW'(DEPTH));
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;

  // Storage: written without reset so that a RAM can be inferred
  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr] <= {push_noise, push_perr, push_data};
  end

  assign {head_noise, head_perr, head_data} = mem[rptr];

  always_comb begin
    cnt_nx = cnt;
    if (push_ok && !pop_ok)      cnt_nx = cnt + 1'b1;
    else if (pop_ok && !push_ok) cnt_nx = cnt - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      cnt <= cnt_nx;
      if (push_ok) wptr <= (wptr == PW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
      if (pop_ok)  rptr <= (rptr == PW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
    end
  end

  // Sticky flags: noise and parity clear once the queue drains
  always_ff @(posedge clk) begin
    if (rst) begin
      noise_seen <= 1'b0;
      perr_seen  <= 1'b0;
      overrun    <= 1'b0;
    end else begin
      if (cnt_nx == '0) begin
        noise_seen <= 1'b0;
        perr_seen  <= 1'b0;
      end else begin
        if (push_ok && push_noise) noise_seen <= 1'b1;
        if (push_ok && push_perr)  perr_seen  <= 1'b1;
      end
      if (push && full)  overrun <= 1'b1;
      else if (ovr_clr)  overrun <= 1'b0;
    end
  end

  p_no_overflow_r9: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(DEPTH));
  p_drop_sets_ovr_r9: assert property (@(posedge clk) disable iff (rst)
    (push && full) |=> (overrun && full));
  p_sticky_clear_r10: assert property (@(posedge clk) disable iff (rst)
    empty |-> (!noise_seen && !perr_seen));
  p_noise_set_r10: assert property (@(posedge clk) disable iff (rst)
    (push && !full && push_noise) |=> noise_seen);
endmodule

// File: rtl/tx_hold_reg.sv
module tx_hold_reg #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [DW-1:0] load_data,
  input  logic          pop,
  output logic [DW-1:0] hold_data,
  output logic          hold_full
);
  always_ff @(posedge clk) begin
    if (rst) begin
      hold_full <= 1'b0;
      hold_data <= '0;
    end else if (load) begin
      hold_full <= 1'b1;
      hold_data <= load_data;
    end else if (pop) begin
      hold_full <= 1'b0;
    end
  end

  p_load_fills_r11: assert property (@(posedge clk) disable iff (rst)
    load |=> hold_full);
  p_pop_empties_r11: assert property (@(posedge clk) disable iff (rst)
    (pop && !load) |=> !hold_full);
endmodule

// File: rtl/req_steer.sv
module req_steer #(
  parameter int unsigned NDIR = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NDIR-1:0] en,
  input  logic [NDIR-1:0] pend,
  input  logic [NDIR-1:0] sel,
  output logic [NDIR-1:0] irq,
  output logic [NDIR-1:0] dma
);
  for (genvar d = 0; d < NDIR; d++) begin : g_dir
    always_ff @(posedge clk) begin
      if (rst) begin
        irq[d] <= 1'b0;
        dma[d] <= 1'b0;
      end else begin
        irq[d] <= en[d] && pend[d] && !sel[d];
        dma[d] <= en[d] && pend[d] &&  sel[d];
      end
    end
  end

  p_tx_excl_r1: assert property (@(posedge clk) disable iff (rst)
    !(irq[0] && dma[0]));
  p_tx_route_r1: assert property (@(posedge clk) disable iff (rst)
    (en[0] && pend[0]) |=> (irq[0] != dma[0]));
  p_rx_route_r2: assert property (@(posedge clk) disable iff (rst)
    (en[1] && pend[1] && sel[1]) |=> (dma[1] && !irq[1]));
  p_rx_gate_r3: assert property (@(posedge clk) disable iff (rst)
    !en[1] |=> (!irq[1] && !dma[1]));
endmodule

// File: rtl/uart_host_regs.sv
module uart_host_regs
  import uart_host_pkg::*;
#(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic              rx_push,
  input  logic [DW-1:0]     rx_data,
  input  logic              rx_noise,
  input  logic              rx_perr,
  input  logic              tx_pop,
  output logic [DW-1:0]     tx_data,
  output logic              tx_valid,
  output logic              tx_irq,
  output logic              tx_dma,
  output logic              rx_irq,
  output logic              rx_dma
);
  logic          tx_en_q, rx_en_q, tx_sel_q, rx_sel_q;
  logic [DW-1:0] head_data;
  logic          head_noise, head_perr, empty, full;
  logic          overrun, noise_seen, perr_seen;
  logic          wr_data, rd_data_pop, ovr_clr;
  logic [1:0]    irq_v, dma_v;
  logic [DW-1:0] rd_nx;

  assign wr_data     = bus_wr && (bus_addr == A_DATA);
  assign rd_data_pop = bus_rd && (bus_addr == A_DATA);
  assign ovr_clr     = bus_wr && (bus_addr == A_STAT) && bus_wdata[B_OVR];

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_en_q  <= 1'b0;
      rx_en_q  <= 1'b0;
      tx_sel_q <= 1'b0;
      rx_sel_q <= 1'b0;
    end else if (bus_wr) begin
      if (bus_addr == A_CTRL) begin
        tx_en_q <= bus_wdata[B_TX];
        rx_en_q <= bus_wdata[B_RX];
      end
      if (bus_addr == A_SEL) begin
        tx_sel_q <= bus_wdata[B_TX];
        rx_sel_q <= bus_wdata[B_RX];
      end
    end
  end

  rx_flag_fifo #(.DW(DW), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst(rst),
    .push(rx_push), .push_data(rx_data), .push_noise(rx_noise), .push_perr(rx_perr),
    .pop(rd_data_pop), .ovr_clr(ovr_clr),
    .head_data(head_data), .head_noise(head_noise), .head_perr(head_perr),
    .empty(empty), .full(full), .overrun(overrun),
    .noise_seen(noise_seen), .perr_seen(perr_seen)
  );

  tx_hold_reg #(.DW(DW)) u_txh (
    .clk(clk), .rst(rst),
    .load(wr_data), .load_data(bus_wdata), .pop(tx_pop),
    .hold_data(tx_data), .hold_full(tx_valid)
  );

  req_steer #(.NDIR(2)) u_steer (
    .clk(clk), .rst(rst),
    .en({rx_en_q, tx_en_q}),
    .pend({!empty, !tx_valid}),
    .sel({rx_sel_q, tx_sel_q}),
    .irq(irq_v), .dma(dma_v)
  );

  assign tx_irq = irq_v[DIR_TX];
  assign tx_dma = dma_v[DIR_TX];
  assign rx_irq = irq_v[DIR_RX];
  assign rx_dma = dma_v[DIR_RX];

  always_comb begin
    rd_nx = '0;
    unique case (bus_addr)
      A_DATA: if (!empty) rd_nx = head_data;
      A_CTRL: begin
        rd_nx[B_TX] = tx_en_q;
        rd_nx[B_RX] = rx_en_q;
      end
      A_STAT: begin
        rd_nx[B_TX]    = !tx_valid;
        rd_nx[B_RX]    = !empty;
        rd_nx[B_OVR]   = overrun;
        rd_nx[B_NSEEN] = noise_seen;
        rd_nx[B_PSEEN] = perr_seen;
      end
      A_SEL: begin
        rd_nx[B_TX] = tx_sel_q;
        rd_nx[B_RX] = rx_sel_q;
      end
      A_EXT: if (!empty) begin
        rd_nx[B_NOISY] = head_noise;
        rd_nx[B_PERR]  = head_perr;
      end
      default: rd_nx = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_nx;
  end

  p_sel_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == A_SEL) |=> (!bus_rdata[6] && bus_rdata[4:0] == '0));
  p_ext_empty_r7: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == A_EXT && empty) |=> (bus_rdata == '0));
endmodule

// File: tb/uart_host_regs_bench.sv
`timescale 1ns/1ps
module uart_host_regs_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_wr = 0, bus_rd = 0;
  logic [2:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0, bus_rdata;
  logic       rx_push = 0, rx_noise = 0, rx_perr = 0, tx_pop = 0;
  logic [7:0] rx_data = 0, tx_data;
  logic       tx_valid, tx_irq, tx_dma, rx_irq, rx_dma;

  int total = 0, bad = 0;
  bit done = 0;
  logic [9:0] expq[$];
  int model_cnt = 0;

  always #2.5 clk = ~clk;

  uart_host_regs u_uart_host_regs (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rx_push(rx_push), .rx_data(rx_data),
    .rx_noise(rx_noise), .rx_perr(rx_perr), .tx_pop(tx_pop), .tx_data(tx_data),
    .tx_valid(tx_valid), .tx_irq(tx_irq), .tx_dma(tx_dma), .rx_irq(rx_irq), .rx_dma(rx_dma)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); bus_rd = 1; bus_addr = a;
    @(negedge clk); bus_rd = 0; d = bus_rdata;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  // Driver: pushes a word and records what the scoreboard should see
  task automatic push_word(input logic [7:0] d, input logic n, input logic p);
    @(negedge clk); rx_push = 1; rx_data = d; rx_noise = n; rx_perr = p;
    @(negedge clk); rx_push = 0; rx_noise = 0; rx_perr = 0;
    if (model_cnt < 8) begin
      expq.push_back({n, p, d});
      model_cnt++;
    end
  endtask

  // Monitor: extended flags then data of the head word against the queue
  task automatic pop_check(input string tag);
    logic [7:0] v;
    logic [9:0] e;
    e = expq.pop_front();
    model_cnt--;
    rd(3'd4, v);
    check({"R6 ext ", tag}, v, {e[9], e[8], 6'b0});
    rd(3'd0, v);
    check({"R5 data ", tag}, v, e[7:0]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R12 reset state
    check("R12 tx_irq", tx_irq, 0);
    check("R12 tx_dma", tx_dma, 0);
    check("R12 rx_irq", rx_irq, 0);
    check("R12 rx_dma", rx_dma, 0);
    rd(3'd2, v); check("R12 status", v, 8'h80);
    rd(3'd1, v); check("R12 ctrl", v, 8'h00);
    rd(3'd3, v); check("R12 sel", v, 8'h00);

    // R4 select readback
    wr(3'd3, 8'hFF); rd(3'd3, v); check("R4 sel ones", v, 8'hA0);
    wr(3'd3, 8'h00); rd(3'd3, v); check("R4 sel zero", v, 8'h00);

    // R1 transmit routing
    wr(3'd1, 8'h80); settle();
    check("R1 tx irq", tx_irq, 1); check("R1 tx dma off", tx_dma, 0);
    wr(3'd3, 8'h80); settle();
    check("R1 tx dma", tx_dma, 1); check("R1 tx irq off", tx_irq, 0);
    // R11 holding register
    wr(3'd0, 8'h5A); settle();
    check("R11 valid", tx_valid, 1); check("R11 data", tx_data, 8'h5A);
    check("R1 no req when full", {tx_irq, tx_dma}, 2'b00);
    rd(3'd2, v); check("R11 status tx empty", v[7], 0);
    @(negedge clk); tx_pop = 1; @(negedge clk); tx_pop = 0; settle();
    check("R11 pop", tx_valid, 0); check("R1 dma back", tx_dma, 1);
    wr(3'd1, 8'h00); wr(3'd3, 8'h00);

    // R3 gating, R8, R10
    wr(3'd3, 8'h20);
    push_word(8'hA1, 1, 0); settle();
    check("R3 rx gated sel1", {rx_irq, rx_dma}, 2'b00);
    wr(3'd3, 8'h00); settle();
    check("R3 rx gated sel0", {rx_irq, rx_dma}, 2'b00);
    rd(3'd2, v); check("R8 full", v[5], 1);
    check("R10 noise seen", v[2], 1); check("R10 parity clear", v[1], 0);
    // R2 receive routing
    wr(3'd1, 8'h20); settle();
    check("R2 rx irq", {rx_irq, rx_dma}, 2'b10);
    wr(3'd3, 8'h20); settle();
    check("R2 rx dma", {rx_irq, rx_dma}, 2'b01);
    wr(3'd3, 8'h00);

    push_word(8'hB2, 0, 1);
    push_word(8'hC3, 0, 0);
    rd(3'd2, v); check("R10 parity seen", v[1], 1);
    pop_check("A"); pop_check("B"); pop_check("C");
    // R7 empty behaviour, R10 clear, R8
    rd(3'd4, v); check("R7 ext empty", v, 0);
    rd(3'd0, v); check("R7 data empty", v, 0);
    rd(3'd2, v); check("R10 R8 status empty", v, 8'h80);
    settle();
    check("R2 no rx req empty", {rx_irq, rx_dma}, 2'b00);

    // R9 overflow with varying flags
    for (int i = 0; i < 9; i++) push_word(8'h10 + 8'(i), i[0], i[1]);
    rd(3'd2, v); check("R9 overrun set", v[3], 1);
    wr(3'd2, 8'h08);
    rd(3'd2, v); check("R9 overrun clear", v[3], 0);
    check("R8 still full", v[5], 1);
    for (int i = 0; i < 8; i++) pop_check($sformatf("ovf%0d", i));
    rd(3'd2, v); check("R10 cleared after drain", v, 8'h80);
    rd(3'd4, v); check("R7 ext after drain", v, 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule